// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps edges on an external pin against a 16-bit free-running counter. The counter advances once every four bus clocks. The pin passes through a two-flop synchronizer and then an edge detector. A control bit selects whether rising or falling edges are the active ones. On each active edge the block latches a timestamp into a read-only capture register.

The CPU reaches the block through a synchronous single-cycle register port. This port gives access to:
- the control byte,
- a status byte holding the capture flag,
- the two capture bytes,
- the two counter bytes.

The timestamp equals one more than the counter value that was present just before the pin changed. The timestamp is read as two bytes. Reading the high byte freezes the register until the low byte is read, so the two halves always belong to the same capture.

The control byte also holds enable bits for output compare and overflow interrupts. Those two bits are stored and read back but drive nothing else.

All pins are plain level or strobe signals with no valid/ready flow. A read or write is one cycle wide and is always accepted, so the port never applies back-pressure.

Top module: `icap_timer`

## Requirements
- R1: After reset the counter is 0. It increases by one on the 4th bus clock edge after reset release and on every 4th edge after that. It is read as high byte at address 4 and low byte at address 5.
- R2: On an active edge, the capture register (high byte at address 2, low byte at address 3) loads one plus the counter value held during the clock interval in which the pin changed. The new value is readable from the 3rd rising clock edge after the pin change onwards.
- R3: Control bit 0 selects the active edge: 1 selects rising, 0 selects falling. An edge of the other polarity leaves the capture register and the flag unchanged.
- R4: Every active edge overwrites the capture register, whether the flag is set or clear. The register therefore holds the most recent timestamp.
- R5: A read of address 2 blocks capture transfers until address 3 is read. An active edge during the blocked window still sets the flag, but the register keeps its old value.
- R6: A read of address 3 without a prior read of address 2 does not block later transfers.
- R7: Status bit 0 (address 1) is the capture flag and is set by each active edge. It clears when address 1 is read while the flag is 1 and address 3 is read afterwards.
- R8: `cap_irq` is 1 exactly when the capture flag is 1 and control bit 1 (capture interrupt enable) is 1.
- R9: Reset clears the control byte and the counter. It does not change the capture register.
- R10: Control bits 3:0 are read/write (bit 2 compare enable, bit 3 overflow enable, stored only). Control bits 7:4 read as 0. Writes to any address other than 0 are ignored. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input pin |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
The pin is driven with isolated active edges of both polarities, with bursts of active edges that are never read, and with edges placed between a high-byte read and the matching low-byte read.

Each pattern separates a different behaviour:
- The isolated edges show the timestamp offset and that the polarity select works.
- The bursts show that a set flag does not block overwriting.
- The edges inside a blocked window show that the flag still sets while the data stays frozen, and that a lone low-byte read does not block.

Resets issued after a capture show that the counter and control byte clear while the timestamp survives.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd5;

  typedef struct packed {
    logic ovf_ie;
    logic cmp_ie;
    logic cap_ie;
    logic edge_rise;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/icap_free_counter.sv
module icap_free_counter #(
  parameter int CNT_W = 16,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/icap_edge_sync.sv
module icap_edge_sync #(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             rise_sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             strobe,
  output logic [CNT_W-1:0] cnt_at_edge
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [CNT_W-1:0]  cpipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= pin;
  end

  always_ff @(posedge clk) cpipe[0] <= cnt;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
    always_ff @(posedge clk) cpipe[g] <= cpipe[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  always_comb begin
    if (rise_sel) strobe = sync_q[STAGES-1] & ~prev_q;
    else          strobe = ~sync_q[STAGES-1] & prev_q;
  end

  assign cnt_at_edge = cpipe[STAGES-1];
endmodule

// File: rtl/icap_capture_reg.sv
module icap_capture_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [CNT_W-1:0] cnt_at_edge,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic             rd_status,
  output logic [CNT_W-1:0] cap_val,
  output logic             flag,
  output logic             inhibit
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (strobe && !inhibit) cap_val <= cnt_at_edge + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit <= 1'b0;
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (rd_hi)      inhibit <= 1'b1;
      else if (rd_lo) inhibit <= 1'b0;

      if (rd_status && flag) armed_q <= 1'b1;
      else if (rd_lo)        armed_q <= 1'b0;

      if (strobe)                flag <= 1'b1;
      else if (rd_lo && armed_q) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_regif.sv
module icap_regif
  import icap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cap_val,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_hi,
  output logic              rd_lo,
  output logic              rd_status
);
  localparam int HALF = CNT_W / 2;

  logic              unused_wbits;
  logic [DATA_W-1:0] rmux;

  assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];

  assign rd_hi     = rd && (addr == A_CAP_HI);
  assign rd_lo     = rd && (addr == A_CAP_LO);
  assign rd_status = rd && (addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ctrl <= '0;
    else if (wr && (addr == A_CTRL))  ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_comb begin
    unique case (addr)
      A_CTRL:   rmux = DATA_W'(ctrl);
      A_STATUS: rmux = DATA_W'(flag);
      A_CAP_HI: rmux = DATA_W'(cap_val[CNT_W-1:HALF]);
      A_CAP_LO: rmux = DATA_W'(cap_val[HALF-1:0]);
      A_CNT_HI: rmux = DATA_W'(cnt[CNT_W-1:HALF]);
      A_CNT_LO: rmux = DATA_W'(cnt[HALF-1:0]);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rmux;
  end
endmodule

// File: rtl/icap_timer.sv
module icap_timer
  import icap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV    = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cap_irq
);
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] cnt_at_edge;
  logic [CNT_W-1:0] cap_val;
  logic             cap_strobe;
  logic             cap_flag;
  logic             cap_inhibit;
  logic             rd_hi, rd_lo, rd_status;
  ctrl_t            ctrl;

  icap_free_counter #(.CNT_W(CNT_W), .DIV(DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_val)
  );

  icap_edge_sync #(.CNT_W(CNT_W), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise_sel(ctrl.edge_rise),
    .cnt(cnt_val), .strobe(cap_strobe), .cnt_at_edge(cnt_at_edge)
  );

  icap_capture_reg #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .strobe(cap_strobe), .cnt_at_edge(cnt_at_edge),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_status(rd_status),
    .cap_val(cap_val), .flag(cap_flag), .inhibit(cap_inhibit)
  );

  icap_regif #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cap_val(cap_val), .cnt(cnt_val), .flag(cap_flag),
    .ctrl(ctrl), .rdata(bus_rdata), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_status(rd_status)
  );

  assign cap_irq = cap_flag & ctrl.cap_ie;
endmodule

// File: rtl/icap_timer_chk.sv
module icap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cnt_at_edge,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_strobe,
  input logic             cap_inhibit,
  input logic             cap_flag,
  input logic             cap_ie,
  input logic             rd_lo,
  input logic             cap_irq
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val != $past(cnt_val)) |-> (cnt_val == $past(cnt_val) + CNT_W'(1)));

  // R1
  cnt_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val != $past(cnt_val)) |=> $stable(cnt_val));

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && !cap_inhibit) |=> (cap_val == $past(cnt_at_edge) + CNT_W'(1)));

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_inhibit |=> $stable(cap_val));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> cap_flag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_flag) |-> $past(rd_lo));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> (cap_flag && cap_ie));
endmodule

bind icap_timer icap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_at_edge(cnt_at_edge),
  .cap_val(cap_val), .cap_strobe(cap_strobe), .cap_inhibit(cap_inhibit),
  .cap_flag(cap_flag), .cap_ie(ctrl.cap_ie), .rd_lo(rd_lo), .cap_irq(cap_irq)
);

// File: tb/test_icap_timer.sv
module test_icap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_pin = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_irq;

  int n_run = 0;
  int n_fail = 0;

  logic [15:0] m_cnt;
  int          m_pre;
  logic        m_rise;
  logic [15:0] exp_q[$];
  logic [15:0] last_cap;

  always #2 clk = ~clk;

  icap_timer i_icap_timer (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_irq(cap_irq)
  );

  // Counter model from R1
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0;
      m_pre <= 0;
    end else if (m_pre == 3) begin
      m_pre <= 0;
      m_cnt <= m_cnt + 16'd1;
    end else begin
      m_pre <= m_pre + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [15:0] snap);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    snap = m_cnt;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: a pin change that is an active edge pushes its expected timestamp (R2, R3)
  task automatic drive_pin(input logic v);
    @(negedge clk);
    if (v != cap_pin && v == m_rise) exp_q.push_back(m_cnt + 16'd1);
    cap_pin = v;
  endtask

  // Monitor side: read both capture bytes and compare with the newest expected item
  task automatic check_cap(input string req);
    logic [7:0] hi, lo;
    logic [15:0] s;
    while (exp_q.size() > 1) void'(exp_q.pop_front());
    if (exp_q.size() == 1) last_cap = exp_q.pop_front();
    rd(3'd2, hi, s);
    rd(3'd3, lo, s);
    check(req, {hi, lo}, last_cap);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d, d2;
    logic [15:0] s;
    m_rise = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R9 / R10 reset state
    rd(3'd0, d, s);  check("R9 ctrl after reset", d, 0);
    rd(3'd1, d, s);  check("R7 flag after reset", d, 0);
    check("R8 irq after reset", cap_irq, 0);
    rd(3'd5, d, s);  check("R1 counter lo", d, s[7:0]);
    idle(9);
    rd(3'd5, d, s);  check("R1 counter lo later", d, s[7:0]);
    rd(3'd4, d, s);  check("R1 counter hi", d, s[15:8]);

    // R10 control register
    wr(3'd0, 8'hFF);
    rd(3'd0, d, s);  check("R10 ctrl upper bits zero", d, 8'h0F);
    wr(3'd0, 8'h03);
    m_rise = 1'b1;
    rd(3'd0, d, s);  check("R10 ctrl readback", d, 8'h03);

    // R2 rising capture
    idle(2);
    drive_pin(1'b1);
    idle(4);
    check_cap("R2 capture value");
    rd(3'd1, d, s);  check("R7 flag set", d, 1);
    check("R8 irq with enable", cap_irq, 1);

    // R3 falling edge ignored while rising selected
    drive_pin(1'b0);
    idle(6);
    check_cap("R3 opposite edge ignored");

    // R7 clear sequence (status read above armed it, capture-low read above cleared)
    rd(3'd1, d, s);  check("R7 flag cleared", d, 0);
    check("R8 irq low when flag clear", cap_irq, 0);

    // R4 two captures without service: newest wins
    drive_pin(1'b1);
    idle(5);
    drive_pin(1'b0);
    idle(3);
    drive_pin(1'b1);
    idle(5);
    check_cap("R4 latest capture kept");

    // R3 falling selected
    wr(3'd0, 8'h02);
    m_rise = 1'b0;
    idle(2);
    drive_pin(1'b0);
    idle(5);
    check_cap("R3 falling edge capture");

    // R5 inhibit between high and low reads
    rd(3'd2, d, s);  check("R5 hi before block", d, last_cap[15:8]);
    drive_pin(1'b1);
    idle(3);
    begin
      logic [15:0] blocked;
      logic [15:0] held;
      held = last_cap;
      @(negedge clk);
      blocked = m_cnt + 16'd1;
      cap_pin = 1'b0;
      idle(6);
      rd(3'd3, d, s);  check("R5 lo still old", d, held[7:0]);
      rd(3'd1, d, s);  check("R5 flag set while blocked", d, 1);
      rd(3'd2, d, s);  check("R5 hi still old", d, held[15:8]);
      rd(3'd3, d2, s); check("R5 lo still old again", d2, held[7:0]);
      if (blocked == held) $display("note: blocked timestamp equals held value");
    end
    drive_pin(1'b1);
    idle(3);
    drive_pin(1'b0);
    idle(5);
    check_cap("R5 transfers resume after low read");

    // R6 low read alone does not block
    rd(3'd3, d, s);
    idle(2);
    drive_pin(1'b1);
    idle(3);
    drive_pin(1'b0);
    idle(5);
    check_cap("R6 capture after lone low read");

    // R8 enable off while flag set
    rd(3'd1, d, s);  check("R7 flag set before gating", d, 1);
    check("R8 irq with flag and enable", cap_irq, 1);
    wr(3'd0, 8'h00);
    m_rise = 1'b1;
    idle(1);
    check("R8 irq gated off", cap_irq, 0);

    // R10 writes elsewhere ignored
    wr(3'd2, 8'h5A);
    wr(3'd3, 8'hA5);
    wr(3'd5, 8'h77);
    check_cap("R10 capture write ignored");
    rd(3'd5, d, s);  check("R10 counter write ignored", d, s[7:0]);

    // R9 reset keeps capture, clears control and counter
    wr(3'd0, 8'h0B);
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    rd(3'd0, d, s);  check("R9 ctrl cleared", d, 0);
    rd(3'd5, d, s);  check("R9 counter restarted", d, s[7:0]);
    rd(3'd4, d, s);  check("R9 counter hi zero", d, 0);
    check_cap("R9 capture kept over reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule